// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Master

This block runs read transactions against a three-wire serial EEPROM. A host gives it an
8-bit location and a one-cycle start request. The block raises chip select and sends an
11-bit command frame: a start bit, a two-bit read opcode and the location. It then holds the
serial clock low for a stretched turnaround, switches its capture edge and shifts the
returned word in. It finishes with a one-cycle completion pulse and the word on a parallel
output.

The serial clock idles low throughout. Outgoing bits are changed only while the clock is low, so the
device samples each one on a rising edge. The device answers by driving a leading zero
during the turnaround and then changes its output after each rising edge. The block never
captures that leading zero. It samples each returned bit on the falling edge that follows
the rising edge which launched it.

A parameter sets the clock half-period in system cycles. A second parameter switches to 8-bit
device organisation. The returned line passes through a two-flop synchroniser before it is
used.

Top module: `uwire_rd_master`

## Requirements
- R1: While reset is held and after it is released, chip select, serial clock, data out, busy, done and the data word are all 0.
- R2: A start request seen while idle raises busy and chip select on the next cycle. Data out then already carries the start bit (1) and the serial clock is still low.
- R3: The frame is sent most significant bit first and is exactly 1, 1, 0, then address bits 7 down to 0. Data out never changes while the serial clock is high.
- R4: The serial clock is low whenever chip select is low. Every high or low level lasts at least HALF_DIV system cycles, and each high level lasts exactly HALF_DIV, so a 16-bit read holds the clock high for 27*HALF_DIV cycles.
- R5: The leading zero the device drives after the last address bit is never captured. The returned bits are sampled on falling edges, most significant first, and data_o[15:0] equals the device word at the given address.
- R6: One transaction produces exactly 11 + N rising clock edges, where N is 16, or 8 in 8-bit organisation.
- R7: done_o is high for exactly one cycle, in the cycle where chip select falls. busy_o stays high for 2*HALF_DIV cycles after that, and chip select stays low at least that long before the next transaction.
- R8: A start request while busy_o is high is ignored: no new transaction follows and the current one is not disturbed. This includes a request that falls in the cycle done_o is pulsed.
- R9: With 8-bit organisation selected, only 8 data bits are clocked in. They appear on data_o[7:0] and data_o[15:8] reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 8 | Location to read, captured with the request |
| busy_o | output | 1 | High from acceptance until the inter-transaction gap ends |
| done_o | output | 1 | One-cycle pulse when the word is ready |
| data_o | output | 16 | Word returned by the last read |
| cs_o | output | 1 | Device chip select, active high |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The completion pulse and a fresh start request can land in the same cycle, while the block
still counts out its idle gap. The bench watches the device model's rising-edge count to find
the final falling edge. It then raises start exactly HALF_DIV-1 cycles later, so the request is
sampled on the edge that produces done_o, and it confirms that done_o is high in that cycle. The
request counts as correctly ignored when chip select stays low for a long wait afterwards,
the model registers no new transaction and the returned word still matches the first address.

// File: rtl/uwire_rd_pkg.sv
package uwire_rd_pkg;

    localparam int ADDR_W  = 8;
    localparam int WORD_W  = 16;
    localparam int OP_W    = 2;
    localparam int FRAME_W = 1 + OP_W + ADDR_W;

    localparam logic            LEAD_BIT = 1'b1;
    localparam logic [OP_W-1:0] OP_RD    = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_TURN,
        ST_RD_HI,
        ST_RD_LO,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic cs;
        logic sclk;
        logic mosi;
    } pins_t;

    function automatic logic [FRAME_W-1:0] make_frame(input logic [ADDR_W-1:0] loc);
        return {LEAD_BIT, OP_RD, loc};
    endfunction

endpackage

// File: rtl/uwire_tick_gen.sv
module uwire_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uwire_din_sync.sv
module uwire_din_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uwire_frame_seq.sv
module uwire_frame_seq
    import uwire_rd_pkg::*;
#(
    parameter int NBITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              idle,
    output pins_t             pins,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] data
);
    localparam int MAXB  = (FRAME_W > NBITS) ? FRAME_W : NBITS;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(NBITS - 1);

    seq_state_t         state;
    logic [FRAME_W-1:0] txsh;
    logic [WORD_W-1:0]  rxsh;
    logic [CNT_W-1:0]   cnt;

    assign idle = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pins  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            data  <= '0;
            txsh  <= '0;
            rxsh  <= '0;
            cnt   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        txsh      <= make_frame(addr);
                        pins.cs   <= 1'b1;
                        pins.mosi <= LEAD_BIT;
                        rxsh      <= '0;
                        cnt       <= '0;
                        busy      <= 1'b1;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        pins.sclk <= 1'b1;
                        state     <= ST_CMD_HI;
                    end
                end
                ST_CMD_HI: begin
                    if (tick) begin
                        pins.sclk <= 1'b0;
                        if (cnt == LAST_TX) begin
                            pins.mosi <= 1'b0;
                            cnt       <= '0;
                            state     <= ST_TURN;
                        end else begin
                            txsh      <= {txsh[FRAME_W-2:0], 1'b0};
                            pins.mosi <= txsh[FRAME_W-2];
                            cnt       <= cnt + 1'b1;
                            state     <= ST_CMD_LO;
                        end
                    end
                end
                ST_CMD_LO: begin
                    if (tick) begin
                        pins.sclk <= 1'b1;
                        state     <= ST_CMD_HI;
                    end
                end
                ST_TURN: begin
                    // clock held low for two half-periods while capture edge flips
                    if (tick) begin
                        if (cnt == '0) begin
                            cnt <= CNT_W'(1);
                        end else begin
                            cnt       <= '0;
                            pins.sclk <= 1'b1;
                            state     <= ST_RD_HI;
                        end
                    end
                end
                ST_RD_HI: begin
                    if (tick) begin
                        pins.sclk <= 1'b0;
                        rxsh      <= {rxsh[WORD_W-2:0], din};
                        if (cnt == LAST_RX) begin
                            cnt   <= '0;
                            state <= ST_HOLD;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            state <= ST_RD_LO;
                        end
                    end
                end
                ST_RD_LO: begin
                    if (tick) begin
                        pins.sclk <= 1'b1;
                        state     <= ST_RD_HI;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        pins.cs <= 1'b0;
                        done    <= 1'b1;
                        data    <= rxsh;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            cnt <= CNT_W'(1);
                        end else begin
                            cnt   <= '0;
                            busy  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uwire_rd_master.sv
module uwire_rd_master
    import uwire_rd_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter bit ORG8        = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] data_o,
    output logic              cs_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int NBITS = ORG8 ? 8 : WORD_W;

    logic  tick;
    logic  idle;
    logic  din_s;
    pins_t pins;

    uwire_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .hold (idle),
        .tick (tick)
    );

    uwire_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (miso_i),
        .q   (din_s)
    );

    uwire_frame_seq #(.NBITS(NBITS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (start_i),
        .addr  (addr_i),
        .din   (din_s),
        .idle  (idle),
        .pins  (pins),
        .busy  (busy_o),
        .done  (done_o),
        .data  (data_o)
    );

    assign cs_o   = pins.cs;
    assign sclk_o = pins.sclk;
    assign mosi_o = pins.mosi;
endmodule

// File: rtl/uwire_rd_master_chk.sv
module uwire_rd_master_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_o,
    input logic sclk_o,
    input logic mosi_o
);
    localparam int RW = 16;
    localparam logic [RW-1:0] RMAX = '1;

    logic          sclk_q;
    logic          cs_q;
    logic [RW-1:0] sclk_run;
    logic [RW-1:0] cs_low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            cs_q       <= 1'b0;
            sclk_run   <= RW'(HALF_DIV);
            cs_low_run <= RW'(2 * HALF_DIV);
        end else begin
            sclk_q     <= sclk_o;
            cs_q       <= cs_o;
            sclk_run   <= (sclk_o != sclk_q) ? RW'(1)
                        : ((sclk_run == RMAX) ? RMAX : sclk_run + 1'b1);
            cs_low_run <= cs_o ? '0
                        : ((cs_low_run == RMAX) ? RMAX : cs_low_run + 1'b1);
        end
    end

    a_r2_cs_implies_busy: assert property (@(posedge clk) disable iff (rst)
        cs_o |-> busy_o);

    a_r3_mosi_still_while_high: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && sclk_q) |-> (mosi_o == $past(mosi_o)));

    a_r4_clock_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !cs_o |-> !sclk_o);

    a_r4_level_min_width: assert property (@(posedge clk) disable iff (rst)
        (sclk_o != sclk_q) |-> (sclk_run >= RW'(HALF_DIV)));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_with_deselect: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!cs_o && cs_q));

    a_r7_min_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_o) |-> (cs_low_run >= RW'(2 * HALF_DIV)));

    a_r8_select_only_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind uwire_rd_master uwire_rd_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cs_o    (cs_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
);

// File: tb/uwire_eeprom_model.sv
module uwire_eeprom_model #(
    parameter int NBITS = 16
) (
    input  logic clk,
    input  logic cs,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);
    logic [10:0] cmd;
    logic [15:0] word;
    int          nbits_in;
    int          rises;
    int          rd_idx;
    int          txn_cnt;
    int          hi_cnt;
    bit          reading;
    logic        cs_q;
    logic        sclk_q;
    logic        cs_seen;

    function automatic logic [15:0] content(input logic [7:0] a);
        if (NBITS == 16) return {a ^ 8'hA5, a + 8'h3C};
        return {8'h00, ~a ^ 8'h0F};
    endfunction

    initial begin
        miso = 1'b1; cs_q = 1'b0; sclk_q = 1'b0; cs_seen = 1'b0;
        cmd = '0; word = '0; nbits_in = 0; rises = 0; rd_idx = 0;
        txn_cnt = 0; hi_cnt = 0; reading = 0;
    end

    always @(cs or sclk) begin
        if (cs && !cs_q) begin
            txn_cnt++; rises = 0; nbits_in = 0; cmd = '0; reading = 0; miso = 1'b1;
        end else if (!cs && cs_q) begin
            miso = 1'b1;
        end else if (cs && sclk && !sclk_q) begin
            rises++;
            if (nbits_in < 11) begin
                cmd = {cmd[9:0], mosi};
                nbits_in++;
            end else if (reading && rd_idx > 0) begin
                miso = word[rd_idx-1];
                rd_idx--;
            end
        end else if (cs && !sclk && sclk_q && nbits_in == 11 && !reading) begin
            reading = 1;
            miso    = 1'b0;       // leading zero ahead of the data
            word    = content(cmd[7:0]);
            rd_idx  = NBITS;
        end
        cs_q   = cs;
        sclk_q = sclk;
    end

    always @(negedge clk) begin
        if (cs && !cs_seen) hi_cnt = 0;
        cs_seen = cs;
        if (cs && sclk) hi_cnt++;
    end
endmodule

// File: tb/uwire_rd_master_bench.sv
module uwire_rd_master_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  addr = '0;
    logic        busy_a, done_a, cs_a, sclk_a, mosi_a, miso_a;
    logic        busy_b, done_b, cs_b, sclk_b, mosi_b, miso_b;
    logic [15:0] data_a, data_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    uwire_rd_master #(.HALF_DIV(HALF), .ORG8(1'b0)) u_uwire_rd_master (
        .clk(clk), .rst(rst), .start_i(start), .addr_i(addr),
        .busy_o(busy_a), .done_o(done_a), .data_o(data_a),
        .cs_o(cs_a), .sclk_o(sclk_a), .mosi_o(mosi_a), .miso_i(miso_a));

    uwire_rd_master #(.HALF_DIV(HALF), .ORG8(1'b1)) u_uwire_rd_master_org8 (
        .clk(clk), .rst(rst), .start_i(start), .addr_i(addr),
        .busy_o(busy_b), .done_o(done_b), .data_o(data_b),
        .cs_o(cs_b), .sclk_o(sclk_b), .mosi_o(mosi_b), .miso_i(miso_b));

    uwire_eeprom_model #(.NBITS(16)) mA (.clk(clk), .cs(cs_a), .sclk(sclk_a), .mosi(mosi_a), .miso(miso_a));
    uwire_eeprom_model #(.NBITS(8))  mB (.clk(clk), .cs(cs_b), .sclk(sclk_b), .mosi(mosi_b), .miso(miso_b));

    function automatic logic [15:0] exp16(input logic [7:0] a);
        return {a ^ 8'hA5, a + 8'h3C};
    endfunction

    function automatic logic [15:0] exp8(input logic [7:0] a);
        return {8'h00, ~a ^ 8'h0F};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wait_idle();
        while (busy_a || busy_b) @(negedge clk);
    endtask

    task automatic run_txn(input logic [7:0] a);
        int na = 0, nb = 0, gap_a = -1, k = 0;
        bit in_gap = 0;
        logic [15:0] cap_a = '0, cap_b = '0;
        wait_idle();
        @(negedge clk); addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(cs_a && busy_a && mosi_a && !sclk_a, "R2 accept", {cs_a, busy_a, mosi_a, sclk_a}, 4'b1110);
        forever begin
            if (done_a) begin na++; cap_a = data_a; in_gap = 1; k = 0; end
            else if (in_gap) k++;
            if (in_gap && !busy_a && gap_a < 0) gap_a = k;
            if (done_b) begin nb++; cap_b = data_b; end
            if (na > 0 && nb > 0 && !busy_a && !busy_b) break;
            @(negedge clk);
        end
        chk(cap_a == exp16(a), "R5 data word", cap_a, exp16(a));
        chk(cap_b == exp8(a), "R9 byte word", cap_b, exp8(a));
        chk(mA.cmd == {3'b110, a}, "R3 frame", mA.cmd, {3'b110, a});
        chk(mB.cmd == {3'b110, a}, "R3 frame org8", mB.cmd, {3'b110, a});
        chk(mA.rises == 27, "R6 edges", mA.rises, 27);
        chk(mB.rises == 19, "R6 edges org8", mB.rises, 19);
        chk(mA.hi_cnt == 27 * HALF, "R4 high time", mA.hi_cnt, 27 * HALF);
        chk(na == 1 && nb == 1, "R7 done pulses", {na[15:0], nb[15:0]}, 32'h0001_0001);
        chk(gap_a == 2 * HALF, "R7 busy gap", gap_a, 2 * HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt0;
        repeat (5) @(negedge clk);
        chk({cs_a, sclk_a, mosi_a, busy_a, done_a} == 5'b0 && data_a == 16'h0, "R1 in reset",
            {cs_a, sclk_a, mosi_a, busy_a, done_a}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({cs_a, sclk_a, mosi_a, busy_a, done_a, cs_b, busy_b} == 7'b0 && data_a == 16'h0, "R1 after reset",
            {cs_a, sclk_a, mosi_a, busy_a, done_a, cs_b, busy_b}, 0);

        // sweep of every location, 0 and 255 included
        for (int a = 0; a < 256; a++) run_txn(8'(a));

        // R8: request in the middle of a transaction
        cnt0 = mA.txn_cnt;
        @(negedge clk); addr = 8'h11; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        addr = 8'h22; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();
        chk(mA.txn_cnt == cnt0 + 1, "R8 mid-request ignored", mA.txn_cnt, cnt0 + 1);
        chk(data_a == exp16(8'h11), "R8 word undisturbed", data_a, exp16(8'h11));
        chk(mB.cmd[7:0] == 8'h11, "R8 org8 address kept", mB.cmd[7:0], 8'h11);

        // R8: request in the cycle of the completion pulse
        @(negedge clk); addr = 8'h33; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(cs_a && !sclk_a && mA.rises == 27)) @(negedge clk);
        repeat (HALF - 1) @(negedge clk);
        addr = 8'h44; start = 1'b1;
        @(negedge clk);
        chk(done_a == 1'b1, "R8 request meets done", done_a, 1);
        @(negedge clk); start = 1'b0;
        cnt0 = mA.txn_cnt;
        repeat (40) @(negedge clk);
        chk(!cs_a && !busy_a, "R8 no new select", {cs_a, busy_a}, 0);
        chk(mA.txn_cnt == cnt0, "R8 no new transaction", mA.txn_cnt, cnt0);
        chk(data_a == exp16(8'h33), "R5 word after coincidence", data_a, exp16(8'h33));
        wait_idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule